// File: doc/BRIEF.md
# Interrupt Cause Aggregator

This block gathers thirty-two peripheral interrupt lines into one wired interrupt request for a parent controller. Each line has a sticky cause bit. Software can clear cause bits, force them, and mask them through a small synchronous register port. The port has an address, a write strobe, 32-bit write data and 32-bit read data. Reads are combinational on the address.

A single control bit sets how the whole instance captures its inputs. In level capture, a high input sets its cause bit on every cycle. In rising-edge capture, a cause bit is set only when its input goes from low to high, compared with a registered copy of the inputs. The output is high while any cause bit is set whose mask bit is clear.

A second control bit is a mask for message-signalled interrupts. It is stored and read back, but it drives no logic in this block. Software starts by reading the cause register, serves the unmasked bits, and then acknowledges each one by writing that bit as zero.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset, mask reads 0xFFFFFFFF, cause reads 0, control reads 0, and irqOut is low.
- R2: The registers sit at these offsets: cause 0x00, set-cause 0x08, mask 0x10, control 0x28. Any other offset reads 0, and writes to it change no register.
- R3: Mask bit i set to 1 keeps source i off irqOut, and set to 0 lets it through. The mask reads back as written.
- R4: irqOut is the OR over all bits of cause AND NOT mask, and follows each register update in the same cycle.
- R5: A write to cause clears every bit written as 0 and keeps every bit written as 1. Writing all zeros clears all pending bits.
- R6: A write to set-cause forces to 1 every cause bit written as 1. Bits written as 0 are unchanged. Set-cause always reads as 0.
- R7: With control bit 3 at 0 (level capture), a high input sets its cause bit on every clock. A clear does not hold while the input stays high.
- R8: With control bit 3 at 1 (edge capture), a cause bit is set only when its input is high in one cycle after being low in the cycle before. An input that stays high does not set the bit again after a clear.
- R9: Control keeps only bit 3 (capture mode) and bit 5 (message mask). Both read back, the other bits read 0, and bit 5 has no effect on irqOut.
- R10: When a hardware capture and a software clear reach the same cause bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte offset of the register being accessed |
| busWrEn | input | 1 | Write strobe for busWrData at busAddr |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| srcIrq | input | 32 | Peripheral interrupt lines, one per bit |
| irqOut | output | 1 | Wired interrupt request to the parent |

## Verification
Directed sequences hold an input high across a clear in both capture modes. This separates level capture, where the bit comes straight back, from edge capture, where it stays cleared. They also line up a rising edge with an acknowledge in the same cycle, to show that the capture wins over the clear. Writes to set-cause and cause with sparse and dense patterns show that force and clear act on single bits and touch nothing else. Writes to unmapped offsets show that they fall through to no register. Random traffic with a fixed seed mixes sparse source activity with writes to every offset. Each cycle it compares read-back and irqOut against a model built from the requirements, so that mode switches in the middle of activity are covered.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_SET,
    SEL_MASK,
    SEL_CTRL
  } regSel_e;

  typedef struct packed {
    logic    wrCause;
    logic    wrSet;
    logic    wrMask;
    logic    wrCtrl;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CAUSE_OFS = 'h00,
  parameter int SET_OFS   = 'h08,
  parameter int MASK_OFS  = 'h10,
  parameter int CTRL_OFS  = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CauseAddr = ADDR_W'(CAUSE_OFS);
  localparam logic [ADDR_W-1:0] SetAddr   = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] CtrlAddr  = ADDR_W'(CTRL_OFS);

  regSel_e hitSel;

  always_comb begin
    unique case (busAddr)
      CauseAddr: hitSel = SEL_CAUSE;
      SetAddr:   hitSel = SEL_SET;
      MaskAddr:  hitSel = SEL_MASK;
      CtrlAddr:  hitSel = SEL_CTRL;
      default:   hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdSel   = hitSel;
    strobe.wrCause = busWrEn && (hitSel == SEL_CAUSE);
    strobe.wrSet   = busWrEn && (hitSel == SEL_SET);
    strobe.wrMask  = busWrEn && (hitSel == SEL_MASK);
    strobe.wrCtrl  = busWrEn && (hitSel == SEL_CTRL);
  end

  // R2: at most one register is written per cycle
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCause, strobe.wrSet, strobe.wrMask, strobe.wrCtrl}));

  // R2: writes to an unmapped offset produce no write strobe
  a_r2_unmapped_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != CauseAddr && busAddr != SetAddr &&
     busAddr != MaskAddr && busAddr != CtrlAddr) |->
    !(strobe.wrCause || strobe.wrSet || strobe.wrMask || strobe.wrCtrl));

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int EDGE_BIT = 3,
  parameter int MSG_BIT  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] causeQ, maskQ, srcPrevQ;
  logic [NUM_SRC-1:0] hwSet, swSet, keepBits, causeNext;
  logic               edgeModeQ, msgMaskQ;
  logic [NUM_SRC-1:0] ctrlView;

  // per-source capture cell
  for (genvar i = 0; i < NUM_SRC; i++) begin : gCapture
    always_comb begin
      if (edgeModeQ) hwSet[i] = srcIrq[i] & ~srcPrevQ[i];
      else           hwSet[i] = srcIrq[i];
    end
  end

  always_comb begin
    keepBits  = strobe.wrCause ? wrData : '1;
    swSet     = strobe.wrSet ? wrData : '0;
    causeNext = (causeQ & keepBits) | swSet | hwSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ    <= '0;
      maskQ     <= '1;
      srcPrevQ  <= '0;
      edgeModeQ <= 1'b0;
      msgMaskQ  <= 1'b0;
    end else begin
      causeQ   <= causeNext;
      srcPrevQ <= srcIrq;
      if (strobe.wrMask) maskQ <= wrData;
      if (strobe.wrCtrl) begin
        edgeModeQ <= wrData[EDGE_BIT];
        msgMaskQ  <= wrData[MSG_BIT];
      end
    end
  end

  always_comb begin
    ctrlView           = '0;
    ctrlView[EDGE_BIT] = edgeModeQ;
    ctrlView[MSG_BIT]  = msgMaskQ;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CAUSE: rdData = causeQ;
      SEL_MASK:  rdData = maskQ;
      SEL_CTRL:  rdData = ctrlView;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = |(causeQ & ~maskQ);

  // R3: with every source masked the output stays low
  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1) |-> !irqOut);

  // R6: a software set lands in the cause register on the next cycle
  a_r6_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> ((causeQ & $past(wrData)) == $past(wrData)));

  // R10: a hardware capture is never lost, even against a clear
  a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeQ & $past(hwSet)) == $past(hwSet)));

  // R5: no cause bit rises without a hardware or software set
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeQ & ~$past(causeQ) & ~$past(hwSet | swSet)) == '0));

  // R7: in level mode every high input is pending one cycle later
  a_r7_level_capture: assert property (@(posedge clk) disable iff (!rstN)
    !edgeModeQ |=> ((causeQ & $past(srcIrq)) == $past(srcIrq)));

  // R9: control write updates the capture mode
  a_r9_mode_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCtrl |=> (edgeModeQ == $past(wrData[EDGE_BIT])));

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 6,
  parameter int CAUSE_OFS = 'h00,
  parameter int SET_OFS   = 'h08,
  parameter int MASK_OFS  = 'h10,
  parameter int CTRL_OFS  = 'h28,
  parameter int EDGE_BIT  = 3,
  parameter int MSG_BIT   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic               irqOut
);

  regStrobe_t strobe;

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .SET_OFS(SET_OFS),
    .MASK_OFS(MASK_OFS), .CTRL_OFS(CTRL_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .strobe(strobe)
  );

  irq_agg_datapath #(
    .NUM_SRC(NUM_SRC), .EDGE_BIT(EDGE_BIT), .MSG_BIT(MSG_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .srcIrq(srcIrq), .rdData(busRdData), .irqOut(irqOut)
  );

endmodule

// File: tb/irq_cause_agg_test.sv
`timescale 1ns/1ps
module irq_cause_agg_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] srcIrq = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [31:0] mCause, mMask, mCtrl, mPrev;

  irq_cause_agg uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .srcIrq(srcIrq),
    .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] expRead(input logic [5:0] a);
    case (a)
      6'h00:   return mCause;
      6'h10:   return mMask;
      6'h28:   return mCtrl;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expIrq();
    return |(mCause & ~mMask);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive inputs, advance model, then check irqOut after the edge
  task automatic tick(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] s);
    logic [31:0] hw, c;
    busWrEn = we; busAddr = a; busWrData = d; srcIrq = s;
    hw = mCtrl[3] ? (s & ~mPrev) : s;
    c = mCause;
    if (we && a == 6'h00) c = c & d;
    if (we && a == 6'h08) c = c | d;
    c = c | hw;
    @(posedge clk);
    mCause = c;
    mPrev  = s;
    if (we && a == 6'h10) mMask = d;
    if (we && a == 6'h28) mCtrl = d & 32'h28;
    @(negedge clk);
    check({31'b0, irqOut}, {31'b0, expIrq()}, "R4 irqOut");
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    busWrEn = 1'b0; busAddr = a;
    #1;
    check(busRdData, exp, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mCause = '0; mMask = '1; mCtrl = '0; mPrev = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(6'h00, 32'h0, "R1 cause reset");
    rd(6'h10, 32'hFFFF_FFFF, "R1 mask reset");
    rd(6'h28, 32'h0, "R1 control reset");
    check({31'b0, irqOut}, 32'h0, "R1 irqOut reset");

    // R2 unmapped offsets
    tick(1, 6'h04, 32'hFFFF_FFFF, 0);
    tick(1, 6'h3C, 32'h0000_0000, 0);
    rd(6'h04, 32'h0, "R2 unmapped read");
    rd(6'h10, 32'hFFFF_FFFF, "R2 mask untouched");
    rd(6'h00, 32'h0, "R2 cause untouched");

    // R6 software set
    tick(1, 6'h08, 32'h8000_0001, 0);
    rd(6'h00, 32'h8000_0001, "R6 set-cause forces bits");
    rd(6'h08, 32'h0, "R6 set-cause reads zero");
    tick(1, 6'h08, 32'h0, 0);
    rd(6'h00, 32'h8000_0001, "R6 zero bits no effect");
    check({31'b0, irqOut}, 32'h0, "R3 masked sources quiet");

    // R3 mask
    tick(1, 6'h10, 32'hFFFF_FFFE, 0);
    check({31'b0, irqOut}, 32'h1, "R3 unmasked bit0 drives output");
    rd(6'h10, 32'hFFFF_FFFE, "R3 mask readback");
    tick(1, 6'h10, 32'hFFFF_FFFF, 0);
    check({31'b0, irqOut}, 32'h0, "R3 remasked");

    // R5 acknowledge
    tick(1, 6'h00, 32'hFFFF_FFFE, 0);
    rd(6'h00, 32'h8000_0000, "R5 ack single bit");
    tick(1, 6'h00, 32'h0, 0);
    rd(6'h00, 32'h0, "R5 write zero clears all");

    // R7 level capture
    tick(1, 6'h10, 32'h0, 32'h10);
    rd(6'h00, 32'h10, "R7 level sets bit4");
    tick(1, 6'h00, 32'h0, 32'h10);
    rd(6'h00, 32'h10, "R7 clear does not hold while high");
    tick(0, 6'h00, 32'h0, 32'h0);
    tick(1, 6'h00, 32'h0, 32'h0);
    rd(6'h00, 32'h0, "R7 clear after release");

    // R8 edge capture
    tick(1, 6'h28, 32'h08, 32'h80);
    tick(1, 6'h00, 32'h0, 32'h80);
    rd(6'h28, 32'h08, "R8 edge mode set");
    tick(0, 6'h00, 32'h0, 32'h0);
    tick(0, 6'h00, 32'h0, 32'h80);
    rd(6'h00, 32'h80, "R8 rising edge captured");
    tick(1, 6'h00, 32'h0, 32'h80);
    tick(0, 6'h00, 32'h0, 32'h80);
    rd(6'h00, 32'h0, "R8 held input not recaptured");

    // R10 capture beats clear
    tick(1, 6'h00, 32'h0, 32'h280);
    rd(6'h00, 32'h200, "R10 rise during clear survives");

    // R9 control bits
    tick(1, 6'h28, 32'hFFFF_FFFF, 32'h280);
    rd(6'h28, 32'h28, "R9 only bits 3 and 5 kept");
    check({31'b0, irqOut}, 32'h1, "R9 message mask leaves irqOut alone");
    tick(1, 6'h28, 32'h20, 32'h0);
    rd(6'h28, 32'h20, "R9 bit5 alone");

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a;
      logic [31:0] d, s;
      case ($urandom_range(0, 6))
        0: a = 6'h00;
        1: a = 6'h08;
        2: a = 6'h10;
        3: a = 6'h28;
        4: a = 6'h04;
        5: a = 6'h18;
        default: a = 6'h3C;
      endcase
      d = $urandom;
      if (a == 6'h00) d = ~($urandom & $urandom);
      if (a == 6'h08) d = $urandom & $urandom & $urandom;
      s = $urandom & $urandom & $urandom;
      tick($urandom_range(0, 1) == 1, a, d, s);
      case ($urandom_range(0, 3))
        0: rd(6'h00, expRead(6'h00), "R5 R7 R8 R10 random cause");
        1: rd(6'h10, expRead(6'h10), "R3 random mask");
        2: rd(6'h28, expRead(6'h28), "R9 random control");
        default: rd(6'h08, expRead(6'h08), "R2 R6 random set-cause read");
      endcase
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule